// File: doc/BRIEF.md
# Half-Bridge PWM Priority Interlock with Dead Time

This block turns two already-synchronised PWM request inputs into two gate commands for the high and low switch of a half bridge. Each request first passes a glitch filter: a level change is accepted only once it has held for a fixed number of clock cycles. Both edges are delayed by the same amount, so an accepted pulse keeps its width. The filtered requests then go to an interlock. There, channel A always wins. A request on A pulls gate B low at once. A request on B is ignored for as long as A is requested.

Neither gate turns on until both gates have been low for a minimum dead time. A gap on the inputs that is already longer than this floor passes through unchanged. If B is tied high and A carries the PWM pattern, the two gates come out complementary, with the dead time inserted at each changeover. A disable input forces both gates low and restarts the dead-time count. All timing values are parameters given in clock cycles.

Top module: `pwm_pair_interlock`

## Requirements
- R1: While reset is asserted, both gate outputs are low.
- R2: A pulse on either request input shorter than REJECT cycles (default 10) causes no change on any gate output.
- R3: A request pulse of PASS cycles or longer (default 35) is accepted. The gate rises and falls FILT+1 cycles after the corresponding input edge, where FILT = (REJECT+PASS)/2 (default 22, giving a latency of 23 cycles), so the output pulse has the same width as the input pulse. A gate goes low on the cycle after its filtered request drops.
- R4: The two gate outputs are never high in the same cycle.
- R5: A filtered A request drives gate B low on the next cycle and holds it low. A B request that starts and ends while A is requested produces no B output. When both filtered requests rise in the same cycle, only A turns on.
- R6: A gate turns on only after both gates have been low for DEAD consecutive cycles (default 40). When one gate falls and the other is already requested, the other gate rises exactly DEAD cycles later.
- R7: If the gap between one input falling and the other input rising is longer than DEAD, the same gap appears between the gate outputs.
- R8: With B held high and a pulse on A, gate B falls one latency after A rises on the input. Gate A rises DEAD cycles after gate B falls. Gate A falls one latency after A falls on the input, and gate B rises DEAD cycles after that.
- R9: While disable is high, both gates are low from the next cycle on. The dead-time count is cleared, so a gate that is still requested turns on DEAD cycles after disable is released. This includes a disable of a single cycle that lands exactly on a scheduled turn-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dis_i | input | 1 | Global disable, forces both gates low |
| in_a_i | input | 1 | Channel A PWM request (priority channel) |
| in_b_i | input | 1 | Channel B PWM request |
| gate_a_o | output | 1 | Gate command for switch A |
| gate_b_o | output | 1 | Gate command for switch B |

## Verification
Two pairs of functions can act in the same clock cycle, and each pair is exercised.

- **Priority and turn-on.** Both filtered requests can rise on the same edge from idle, once the dead time has already expired. The bench provokes this by raising both inputs in the same cycle. It expects exactly one event, A rising one latency later. Gate B must not rise until DEAD cycles after A falls.
- **Disable and turn-on.** Disable can coincide with the cycle in which a dead-time turn-on is due. The bench provokes this with a single-cycle disable placed on that edge. It judges the result by checking that the turn-on slips to a full DEAD cycles after the disable edge.

// File: rtl/pwm_ilk_pkg.sv
package pwm_ilk_pkg;
  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_A_ON = 2'd1,
    GATE_B_ON = 2'd2
  } gate_st_e;
endpackage

// File: rtl/pwm_glitch_filter.sv
module pwm_glitch_filter #(
  parameter int FILT = 22
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int CW = (FILT > 2) ? $clog2(FILT) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  // level must differ from the output for FILT consecutive edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (in_i != out_q) begin
      if (cnt_q == LAST) begin
        out_q <= in_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/pwm_dead_interlock.sv
module pwm_dead_interlock
  import pwm_ilk_pkg::*;
#(
  parameter int DEAD = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dis_i,
  input  logic req_a_i,
  input  logic req_b_i,
  output logic gate_a_o,
  output logic gate_b_o
);
  localparam int CW = $clog2(DEAD + 1);
  localparam logic [CW-1:0] DEAD_M1 = CW'(DEAD - 1);
  localparam logic [CW-1:0] DEAD_C  = CW'(DEAD);

  gate_st_e      state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ready;

  // the cycle being evaluated is the DEAD-th low cycle
  assign ready = (cnt_q >= DEAD_M1);

  always_comb begin
    state_d = state_q;
    if (dis_i) begin
      state_d = GATE_IDLE;
    end else begin
      unique case (state_q)
        GATE_IDLE: begin
          if (ready && req_a_i)      state_d = GATE_A_ON;
          else if (ready && req_b_i) state_d = GATE_B_ON;
        end
        GATE_A_ON: if (!req_a_i) state_d = GATE_IDLE;
        GATE_B_ON: if (req_a_i || !req_b_i) state_d = GATE_IDLE;
        default:   state_d = GATE_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (dis_i || (state_q != GATE_IDLE)) cnt_d = '0;
    else if (cnt_q != DEAD_C)            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GATE_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gate_a_o = (state_q == GATE_A_ON);
  assign gate_b_o = (state_q == GATE_B_ON);
endmodule

// File: rtl/pwm_pair_interlock.sv
module pwm_pair_interlock #(
  parameter int DEAD   = 40,
  parameter int REJECT = 10,
  parameter int PASS   = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dis_i,
  input  logic in_a_i,
  input  logic in_b_i,
  output logic gate_a_o,
  output logic gate_b_o
);
  // threshold centred between reject and pass limits
  localparam int FILT = (REJECT + PASS) / 2;

  logic [1:0] raw;
  logic [1:0] filt;
  logic       req_a, req_b;

  assign raw = {in_b_i, in_a_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    pwm_glitch_filter #(.FILT(FILT)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (raw[g]),
      .out_o (filt[g])
    );
  end

  assign req_a = filt[0];
  assign req_b = filt[1];

  pwm_dead_interlock #(.DEAD(DEAD)) u_ilk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dis_i   (dis_i),
    .req_a_i (req_a),
    .req_b_i (req_b),
    .gate_a_o(gate_a_o),
    .gate_b_o(gate_b_o)
  );
endmodule

// File: rtl/pwm_pair_interlock_chk.sv
module pwm_pair_interlock_chk #(
  parameter int DEAD = 40
) (
  input logic clk_i,
  input logic rst_ni,
  input logic dis_i,
  input logic req_a_i,
  input logic req_b_i,
  input logic gate_a_i,
  input logic gate_b_i
);
  localparam int CW = $clog2(DEAD + 1);
  localparam logic [CW-1:0] DEAD_C = CW'(DEAD);

  logic [CW-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  low_run <= '0;
    else if (gate_a_i || gate_b_i) low_run <= '0;
    else if (low_run != DEAD_C)   low_run <= low_run + 1'b1;
  end

  assert_no_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_a_i && gate_b_i));

  assert_dis_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> (!gate_a_i && !gate_b_i));

  assert_dead_a_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_a_i) |-> (low_run >= DEAD_C));

  assert_dead_b_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_b_i) |-> (low_run >= DEAD_C));

  assert_a_preempt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_a_i |=> !gate_b_i);

  assert_follow_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_a_i |=> !gate_a_i);

  assert_follow_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_b_i |=> !gate_b_i);
endmodule

bind pwm_pair_interlock pwm_pair_interlock_chk #(.DEAD(DEAD)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .dis_i   (dis_i),
  .req_a_i (req_a),
  .req_b_i (req_b),
  .gate_a_i(gate_a_o),
  .gate_b_i(gate_b_o)
);

// File: tb/sim_pwm_pair_interlock.sv
module sim_pwm_pair_interlock;
  localparam int DEAD   = 40;
  localparam int REJECT = 10;
  localparam int PASS   = 35;
  localparam int LAT    = (REJECT + PASS) / 2 + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dis = 1'b0;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic gate_a, gate_b;

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_pair_interlock #(.DEAD(DEAD), .REJECT(REJECT), .PASS(PASS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .dis_i(dis),
    .in_a_i(in_a), .in_b_i(in_b),
    .gate_a_o(gate_a), .gate_b_o(gate_b)
  );

  typedef struct {
    bit    ch;
    bit    lvl;
    int    at;
    string req;
  } ev_t;

  ev_t exp_q[$];
  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  task automatic push(input bit ch, input bit lvl, input int at, input string req);
    exp_q.push_back('{ch, lvl, at, req});
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic on_edge(input bit ch, input bit lvl);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R2/R5 unexpected edge: actual ch%0d lvl%0d at %0d expected none",
               ch, lvl, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.ch != ch || e.lvl != lvl || e.at != cyc) begin
        fails++;
        $display("FAIL %s edge: actual ch%0d lvl%0d at %0d expected ch%0d lvl%0d at %0d",
                 e.req, ch, lvl, cyc, e.ch, e.lvl, e.at);
      end
    end
  endtask

  // monitor: compares every output edge with the scoreboard
  initial begin
    bit pa = 1'b0;
    bit pb = 1'b0;
    forever begin
      @(negedge clk);
      if (gate_a !== pa) begin
        on_edge(1'b0, gate_a);
        pa = gate_a;
      end
      if (gate_b !== pb) begin
        on_edge(1'b1, gate_b);
        pb = gate_b;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int p;
    idle(3);
    check(gate_a == 1'b0 && gate_b == 1'b0, "R1", "gates in reset",
          {gate_a, gate_b}, 0);
    rst_ni = 1'b1;
    idle(100);

    // R3: plain A pulse of 50 cycles
    p = cyc;
    push(0, 1, p + LAT, "R3");
    push(0, 0, p + 50 + LAT, "R3");
    in_a = 1'b1; idle(50); in_a = 1'b0;
    idle(100);

    // R2: glitches of REJECT-1 cycles on both inputs
    in_a = 1'b1; idle(REJECT - 1); in_a = 1'b0;
    idle(20);
    in_b = 1'b1; idle(REJECT - 1); in_b = 1'b0;
    idle(50);
    check(gate_a == 1'b0 && gate_b == 1'b0, "R2", "gates after glitches",
          {gate_a, gate_b}, 0);
    idle(50);

    // R3: pulse of exactly PASS cycles on B keeps its width
    p = cyc;
    push(1, 1, p + LAT, "R3");
    push(1, 0, p + PASS + LAT, "R3");
    in_b = 1'b1; idle(PASS); in_b = 1'b0;
    idle(100);

    // R8: B held high, A pulses
    p = cyc;
    push(1, 1, p + LAT, "R8");
    in_b = 1'b1; idle(60);
    p = cyc;
    push(1, 0, p + LAT, "R8");
    push(0, 1, p + LAT + DEAD, "R8");
    push(0, 0, p + 100 + LAT, "R8");
    push(1, 1, p + 100 + LAT + DEAD, "R8");
    in_a = 1'b1; idle(100); in_a = 1'b0;
    idle(100);
    p = cyc;
    push(1, 0, p + LAT, "R8");
    in_b = 1'b0;
    idle(100);

    // R7: input gap of 60 cycles passes unchanged
    p = cyc;
    push(0, 1, p + LAT, "R7");
    push(0, 0, p + 50 + LAT, "R7");
    push(1, 1, p + 110 + LAT, "R7");
    push(1, 0, p + 160 + LAT, "R7");
    in_a = 1'b1; idle(50); in_a = 1'b0;
    idle(60); in_b = 1'b1; idle(50); in_b = 1'b0;
    idle(100);

    // R6: input gap of 10 cycles is stretched to DEAD
    p = cyc;
    push(0, 1, p + LAT, "R6");
    push(0, 0, p + 60 + LAT, "R6");
    push(1, 1, p + 60 + LAT + DEAD, "R6");
    push(1, 0, p + 200 + LAT, "R6");
    in_a = 1'b1; idle(60); in_a = 1'b0;
    idle(10); in_b = 1'b1; idle(130); in_b = 1'b0;
    idle(100);

    // R5: B pulse inside an A pulse is ignored
    p = cyc;
    push(0, 1, p + LAT, "R5");
    push(0, 0, p + 200 + LAT, "R5");
    in_a = 1'b1; idle(50);
    in_b = 1'b1; idle(50); in_b = 1'b0;
    idle(100); in_a = 1'b0;
    idle(100);
    check(gate_b == 1'b0, "R5", "gate B after masked request", gate_b, 0);

    // R5: both inputs rise together, A wins, B follows after dead time
    p = cyc;
    push(0, 1, p + LAT, "R5");
    push(0, 0, p + 80 + LAT, "R5");
    push(1, 1, p + 80 + LAT + DEAD, "R5");
    push(1, 0, p + 200 + LAT, "R5");
    in_a = 1'b1; in_b = 1'b1;
    idle(80); in_a = 1'b0;
    idle(120); in_b = 1'b0;
    idle(100);

    // R9: disable while A is on, then release
    p = cyc;
    push(0, 1, p + LAT, "R9");
    push(0, 0, p + 61, "R9");
    push(0, 1, p + 80 + DEAD, "R9");
    push(0, 0, p + 150 + LAT, "R9");
    in_a = 1'b1; idle(60);
    dis = 1'b1; idle(10);
    check(gate_a == 1'b0 && gate_b == 1'b0, "R9", "gates while disabled",
          {gate_a, gate_b}, 0);
    idle(10); dis = 1'b0;
    idle(70); in_a = 1'b0;
    idle(100);

    // R9: one-cycle disable on the edge of a scheduled turn-on
    p = cyc;
    push(0, 1, p + LAT + DEAD, "R9");
    push(0, 0, p + 100 + LAT, "R9");
    in_a = 1'b1; idle(LAT - 1);
    dis = 1'b1; idle(1); dis = 1'b0;
    idle(100 - LAT); in_a = 1'b0;
    idle(100);

    check(exp_q.size() == 0, "R3", "missing gate edges", exp_q.size(), 0);
    check(gate_a == 1'b0 && gate_b == 1'b0, "R4", "final gates",
          {gate_a, gate_b}, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule